// File: doc/BRIEF.md
# Watchdog Timer with Reset Stretcher

This block watches for software that has stopped running. Its own clock drives a prescaler and a small counter, chained as a single binary count. Software shows that it is alive by writing to a fixed service address. If no such write arrives before the chain reaches its terminal value, the block pulls an active-low reset output low for a fixed number of clock cycles. It also sets a cause flag that only power-on reset clears.

A configuration bit selects one of two timeout lengths. A stop-instruction pulse clears the prescaler. A disable input, used in monitor or break mode, holds the timebase at zero and keeps the reset output from firing.

The controller has three states:

- **COUNT**: counting.
- **STRETCH**: the reset pulse is being driven.
- **HALT**: disabled.

The transitions between them are:

- COUNT→HALT when the disable input is high.
- COUNT→STRETCH on a terminal count that is not serviced in the same cycle.
- STRETCH→COUNT after the last cycle of the pulse.
- HALT→COUNT when the disable input falls.

Top module: `cop_watchdog`

## Requirements
- R1: While `por_n` is low, `rst_out_n` is 1, `wd_flag` is 0, and the prescaler, counter and pulse counter are zero.
- R2: With `rate_long`=1 and no service, the chain fires at 2^(PRE_W+CNT_W)−2^LO_KEEP (2^18−16 by default). `rst_out_n` falls after the (2^(PRE_W+CNT_W)−2^LO_KEEP+1)-th rising edge after `por_n` is released.
- R3: With `rate_long`=0, the terminal value is reached when the low SHORT_TAP bits of the chain equal 2^SHORT_TAP−2^LO_KEEP (8176 by default). `rst_out_n` falls after the (2^SHORT_TAP−2^LO_KEEP+1)-th edge.
- R4: A cycle with `bus_wr`=1 and `bus_addr`=0xFFFF is a service. A service clears the counter and prescaler bits LO_KEEP and above. The low LO_KEEP prescaler bits keep counting, modulo 2^LO_KEEP. A write to any other address has no effect.
- R5: An overflow holds `rst_out_n` low for exactly PULSE_LEN (32) cycles. Counting then resumes from zero.
- R6: `wd_flag` rises with the first low cycle of a watchdog reset. It then stays 1 until the next `por_n` assertion.
- R7: A service in the same cycle as the terminal count wins: no reset is produced.
- R8: A `stop_pulse` clears all prescaler bits and leaves the counter unchanged.
- R9: While `wd_disable` is high, the chain is held at zero and no reset starts. A reset pulse that is already running completes its full length. Counting restarts from zero one cycle after `wd_disable` falls.
- R10: A change of `rate_long` takes effect on the next cycle and does not clear the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wd | input | 1 | Watchdog clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| rate_long | input | 1 | 1 selects the long timeout, 0 the short one |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| stop_pulse | input | 1 | One-cycle pulse marking a stop instruction |
| wd_disable | input | 1 | Monitor or break-mode disable |
| rst_out_n | output | 1 | Active-low reset drive |
| wd_flag | output | 1 | Watchdog-cause status flag |

## Verification
The bench runs on a reduced configuration: a 6-bit prescaler, a 3-bit counter and 2 kept low bits, which gives timeouts of 508 and 28 cycles. It compares the outputs every cycle against an arithmetic model.

- **Service-time sweeps** in both rates place the service write at every offset (short rate) or every eleventh offset (long rate). These separate a correct upper-bit clear with a running low field from a full clear or no clear.
- **Targeted runs** cover a service on the terminal cycle and a write to a neighbouring address. They also cover stop pulses at chain values where the prescaler carries, disable raised both before and during a pulse, and rate flips in both directions mid-count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_COUNT   = 2'd0,
        ST_STRETCH = 2'd1,
        ST_HALT    = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdog_svc_decode.sv
module wdog_svc_decode #(
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              svc
);
    // Any data value counts; only the address qualifies the write.
    always_comb svc = bus_wr && (bus_addr == SVC_ADDR);
endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
    parameter int PRE_W     = 12,
    parameter int CNT_W     = 6,
    parameter int LO_KEEP   = 4,
    parameter int SHORT_TAP = 13
) (
    input  logic clk,
    input  logic por_n,
    input  logic clr,
    input  logic svc,
    input  logic stop,
    input  logic rate_long,
    output logic tc
);
    localparam int W = PRE_W + CNT_W;
    localparam logic [W-1:0]         ONE_W  = W'(1);
    localparam logic [LO_KEEP-1:0]   ONE_LO = LO_KEEP'(1);
    localparam logic [W-1:0]         TERM_L = {{(W-LO_KEEP){1'b1}}, {LO_KEEP{1'b0}}};
    localparam logic [SHORT_TAP-1:0] TERM_S = {{(SHORT_TAP-LO_KEEP){1'b1}}, {LO_KEEP{1'b0}}};

    logic [W-1:0] chain;
    logic [W-1:0] nxt;

    always_comb begin
        if (svc && stop) begin
            nxt = '0;
        end else if (svc) begin
            nxt = '0;
            nxt[LO_KEEP-1:0] = chain[LO_KEEP-1:0] + ONE_LO;
        end else if (stop) begin
            nxt = chain;
            nxt[PRE_W-1:0] = '0;
        end else begin
            nxt = chain + ONE_W;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)   chain <= '0;
        else if (clr) chain <= '0;
        else          chain <= nxt;
    end

    always_comb tc = rate_long ? (chain == TERM_L) : (chain[SHORT_TAP-1:0] == TERM_S);

    AST_SVC_CLEARS_UPPER: assert property (@(posedge clk) disable iff (!por_n)
        (svc && !clr) |=> (chain[W-1:LO_KEEP] == '0)); // R4
    AST_STOP_CLEARS_PRE: assert property (@(posedge clk) disable iff (!por_n)
        (stop && !clr) |=> (chain[PRE_W-1:0] == '0)); // R8
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> (chain == '0)); // R9
endmodule

// File: rtl/wdog_stretch_fsm.sv
module wdog_stretch_fsm
    import wdog_pkg::*;
#(
    parameter int PULSE_LEN = 32
) (
    input  logic clk,
    input  logic por_n,
    input  logic tc,
    input  logic svc,
    input  logic dis,
    output logic rst_out_n,
    output logic wd_flag,
    output logic chain_clr
);
    localparam int PC_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_LEN - 1);
    localparam logic [PC_W-1:0] PC_ONE  = PC_W'(1);

    wd_state_e   state, state_nxt;
    logic [PC_W-1:0] pcnt;
    logic        fire;

    always_comb fire = (state == ST_COUNT) && !dis && tc && !svc;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_COUNT:   if (dis) state_nxt = ST_HALT;
                        else if (fire) state_nxt = ST_STRETCH;
            ST_STRETCH: if (pcnt == PC_LAST) state_nxt = ST_COUNT;
            ST_HALT:    if (!dis) state_nxt = ST_COUNT;
            default:    state_nxt = ST_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state   <= ST_COUNT;
            pcnt    <= '0;
            wd_flag <= 1'b0;
        end else begin
            state <= state_nxt;
            if (fire) begin
                pcnt    <= '0;
                wd_flag <= 1'b1;
            end else if (state == ST_STRETCH) begin
                pcnt <= pcnt + PC_ONE;
            end
        end
    end

    always_comb begin
        rst_out_n = (state != ST_STRETCH);
        chain_clr = (state != ST_COUNT) || dis || fire;
    end

    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_out_n) |-> ($past(pcnt) == PC_LAST)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        wd_flag |=> wd_flag); // R6
    AST_LOW_HAS_FLAG: assert property (@(posedge clk) disable iff (!por_n)
        !rst_out_n |-> wd_flag); // R6
    AST_SERVICE_WINS: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_COUNT && tc && svc) |=> rst_out_n); // R7
    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        (state != ST_STRETCH && dis) |=> rst_out_n); // R9
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog #(
    parameter int                PRE_W     = 12,
    parameter int                CNT_W     = 6,
    parameter int                LO_KEEP   = 4,
    parameter int                SHORT_TAP = 13,
    parameter int                PULSE_LEN = 32,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] SVC_ADDR  = '1
) (
    input  logic              clk_wd,
    input  logic              por_n,
    input  logic              rate_long,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              stop_pulse,
    input  logic              wd_disable,
    output logic              rst_out_n,
    output logic              wd_flag
);
    logic svc, tc, chain_clr;

    wdog_svc_decode #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_dec (
        .bus_wr(bus_wr), .bus_addr(bus_addr), .svc(svc)
    );

    wdog_timebase #(.PRE_W(PRE_W), .CNT_W(CNT_W), .LO_KEEP(LO_KEEP), .SHORT_TAP(SHORT_TAP)) u_tb (
        .clk(clk_wd), .por_n(por_n), .clr(chain_clr), .svc(svc),
        .stop(stop_pulse), .rate_long(rate_long), .tc(tc)
    );

    wdog_stretch_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk(clk_wd), .por_n(por_n), .tc(tc), .svc(svc), .dis(wd_disable),
        .rst_out_n(rst_out_n), .wd_flag(wd_flag), .chain_clr(chain_clr)
    );
endmodule

// File: tb/sim_cop_watchdog.sv
`timescale 1ns/1ps
module sim_cop_watchdog;
    localparam int PRE = 6, CNT = 3, LO = 2, ST = 5, PL = 32;
    localparam int FMOD = 1 << (PRE + CNT);
    localparam int TL   = FMOD - (1 << LO);
    localparam int SMOD = 1 << ST;
    localparam int TS   = SMOD - (1 << LO);
    localparam int LMOD = 1 << LO;
    localparam int PMOD = 1 << PRE;

    logic clk = 0, por_n = 0, rate_long = 0, bus_wr = 0, stop_pulse = 0, wd_disable = 0;
    logic [15:0] bus_addr = '0;
    logic rst_out_n, wd_flag;
    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    cop_watchdog #(.PRE_W(PRE), .CNT_W(CNT), .LO_KEEP(LO), .SHORT_TAP(ST), .PULSE_LEN(PL)) u0 (
        .clk_wd(clk), .por_n(por_n), .rate_long(rate_long), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .stop_pulse(stop_pulse), .wd_disable(wd_disable), .rst_out_n(rst_out_n), .wd_flag(wd_flag)
    );

    // Arithmetic model: 0 counting, 1 pulse, 2 disabled
    int mval = 0, mst = 0, mpc = 0;
    bit mflag = 0;
    always @(posedge clk or negedge por_n) begin
        bit s, t;
        if (!por_n) begin
            mval = 0; mst = 0; mpc = 0; mflag = 0;
        end else if (mst == 0) begin
            if (wd_disable) begin
                mst = 2; mval = 0;
            end else begin
                s = bus_wr && (bus_addr == 16'hFFFF);
                t = rate_long ? (mval == TL) : ((mval % SMOD) == TS);
                if (t && !s) begin
                    mst = 1; mpc = 0; mflag = 1; mval = 0;
                end else if (s && stop_pulse) mval = 0;
                else if (s) mval = ((mval % LMOD) + 1) % LMOD;
                else if (stop_pulse) mval = mval - (mval % PMOD);
                else mval = (mval + 1) % FMOD;
            end
        end else if (mst == 1) begin
            mval = 0;
            if (mpc == PL - 1) mst = 0; else mpc++;
        end else begin
            mval = 0;
            if (!wd_disable) mst = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        checks++;
        if (rst_out_n !== (mst != 1) || wd_flag !== mflag) begin
            errors++;
            $display("FAIL %s: rst_out_n/wd_flag actual %b/%b expected %b/%b",
                     cur_req, rst_out_n, wd_flag, (mst != 1), mflag);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_por(input bit rl);
        por_n = 0; bus_wr = 0; stop_pulse = 0; wd_disable = 0; rate_long = rl;
        run(2);
        por_n = 1;
    endtask

    task automatic pulse_svc(input logic [15:0] a);
        bus_wr = 1; bus_addr = a;
        tick();
        bus_wr = 0; bus_addr = '0;
    endtask

    task automatic measure_fall(output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            tick(); n++;
            if (!rst_out_n) break;
        end
    endtask

    task automatic count_low(output int m, input int raise_dis_at);
        m = 1;
        for (int i = 0; i < 100; i++) begin
            if (m == raise_dis_at) wd_disable = 1;
            tick();
            if (!rst_out_n) m++; else break;
        end
    endtask

    initial begin
        int n, m;
        // R1: reset state
        cur_req = "R1";
        por_n = 0;
        run(3);
        check(rst_out_n === 1'b1, "R1", rst_out_n, 1);
        check(wd_flag === 1'b0, "R1", wd_flag, 0);
        por_n = 1;

        // R3: short timeout
        cur_req = "R3";
        measure_fall(n);
        check(n == TS + 1, "R3", n, TS + 1);
        // R5 / R6: pulse width and flag
        cur_req = "R5";
        count_low(m, 0);
        check(m == PL, "R5", m, PL);
        check(wd_flag === 1'b1, "R6", wd_flag, 1);
        cur_req = "R6";
        run(5);
        check(wd_flag === 1'b1, "R6", wd_flag, 1);
        do_por(1'b1);
        check(wd_flag === 1'b0, "R6", wd_flag, 0);

        // R2: long timeout
        cur_req = "R2";
        measure_fall(n);
        check(n == TL + 1, "R2", n, TL + 1);
        count_low(m, 0);
        check(m == PL, "R5", m, PL);

        // R4: service sweeps
        cur_req = "R4";
        for (int o = 0; o <= TS + 4; o++) begin
            do_por(1'b0); run(o); pulse_svc(16'hFFFF); run(TS + PL + 8);
        end
        for (int o = 0; o <= TL + 2; o += 11) begin
            do_por(1'b1); run(o); pulse_svc(16'hFFFF); run(TL + 8);
        end
        // R4: other address ignored
        do_por(1'b0); run(20); pulse_svc(16'hFFFE);
        measure_fall(n);
        check(n == TS + 1 - 21, "R4", n, TS + 1 - 21);

        // R7: service on terminal cycle
        cur_req = "R7";
        do_por(1'b0); run(TS); pulse_svc(16'hFFFF);
        check(rst_out_n === 1'b1, "R7", rst_out_n, 1);
        check(wd_flag === 1'b0, "R7", wd_flag, 0);
        measure_fall(n);
        check(n == TS + 1 - ((TS % LMOD) + 1), "R7", n, TS + 1 - ((TS % LMOD) + 1));

        // R8: stop clears prescaler only
        cur_req = "R8";
        do_por(1'b1); run(100);
        stop_pulse = 1; tick(); stop_pulse = 0;
        measure_fall(n);
        check(n == TL + 1 - PMOD, "R8", n, TL + 1 - PMOD);
        for (int o = 0; o <= TS; o += 3) begin
            do_por(1'b0); run(o); stop_pulse = 1; tick(); stop_pulse = 0; run(TS + PL + 4);
        end

        // R9: disable
        cur_req = "R9";
        do_por(1'b0); wd_disable = 1; run(100);
        check(rst_out_n === 1'b1, "R9", rst_out_n, 1);
        wd_disable = 0;
        measure_fall(n);
        check(n == TS + 2, "R9", n, TS + 2);
        count_low(m, 5);
        check(m == PL, "R9", m, PL);
        run(40);
        check(rst_out_n === 1'b1, "R9", rst_out_n, 1);
        wd_disable = 0;
        run(3);

        // R10: rate change mid-count
        cur_req = "R10";
        do_por(1'b1); run(20); rate_long = 0;
        measure_fall(n);
        check(n == TS + 1 - 20, "R10", n, TS + 1 - 20);
        do_por(1'b0); run(10); rate_long = 1;
        measure_fall(n);
        check(n == TL + 1 - 10, "R10", n, TL + 1 - 10);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule